// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master driven through two 32-bit registers on a simple write/read register port. Software first loads the outgoing bytes into the data register, left-aligned. It then writes one control word. That word carries a start flag, which chip-select line to use, the transfer direction, a byte count of one to four, the serial clock period and a chip-select guard delay. A final byte in the word is stored but has no effect on the transfer.

Once started, the block drives the selected active-low chip select and waits for the guard delay. It then clocks the bits in SPI mode 0, most significant bit first. Every sampled input bit is shifted into the bottom of the data register. After the last clock edge it waits for the guard delay again, releases the chip select and clears the start flag. Software polls the start flag and reads the data register once the flag is clear. A typical use sends a one-byte status command and then runs a one-byte read, or sends an erase opcode followed by a 24-bit address as a single four-byte write.

Top module: `spi_ctl_master`

## Requirements
- R1: The control register is at address 0x0 and the data register is at address 0x4. Any other address reads 0. The control register reads back as {busy, 0, bits 29:0 as last accepted}. Bit 30 always reads 0. In the control word, bits 29:28 select the chip select, bits 27:26 are the operation, bits 25:24 are the count code, bits 23:16 are the period, bits 15:8 are the guard and bits 7:0 are a stored byte.
- R2: When the block is idle, a control write with bit 31 set starts a transfer. Bit 31 reads 1 from the next cycle until the transfer ends, then reads 0. A control write with bit 31 clear stores the fields and starts nothing.
- R3: A transfer moves (count code + 1) bytes, which gives exactly 8×(code+1) rising SCK edges.
- R4: When the operation code is anything other than 1, MOSI carries the data register MSB first, starting from bit 31.
- R5: Operation code 1 is a read, and MOSI is held low for the whole transfer. After any transfer of n bits, the data register holds (old value << n) | (the n sampled MISO bits), so the last bit received lands in bit 0.
- R6: SCK idles low. Each SCK half period lasts max(1, period>>1) clocks. MOSI changes only while SCK is low, and MISO is sampled on the rising edge.
- R7: The selected chip select goes low max(1, guard) clocks before the first rising SCK edge.
- R8: The chip select stays low for max(1, guard) clocks after the last falling SCK edge, and busy clears in the same cycle the chip select rises.
- R9: Only the chip select whose index is in bits 29:28 is driven low. All the other chip selects stay high.
- R10: While busy is set, writes to the control register and to the data register are ignored.
- R11: A synchronous reset clears busy and both registers, raises every chip select and drives SCK and MOSI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Active-low chip selects |

## Verification
The checker takes for granted that the chip-select index written with a start is always below NUM_CS, so every started transfer drives exactly one line low. It also assumes MISO changes only on a falling SCK edge or when a chip select asserts. The bench uses indices 0 to 3 only. Its slave model updates MISO on the falling SCK edge and reloads it when the chip select asserts, so the rising-edge sample is always clean. The register port is driven away from the clock edge, one access per cycle.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_HOLD  = 2'd3
   } spi_state_t;

   // Control word bits 29:0, most significant field first.
   typedef struct packed {
      logic [1:0] cs_sel;
      logic [1:0] op;
      logic [1:0] len_code;
      logic [7:0] period;
      logic [7:0] guard;
      logic [7:0] aux;
   } spi_cfg_t;

   localparam int CFG_W     = $bits(spi_cfg_t);
   localparam int START_BIT = 31;
   localparam logic [1:0] OP_READ = 2'd1;

endpackage

// File: rtl/spi_ctl_tick.sv
module spi_ctl_tick #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] half_i,
   output logic             tick_o
);
   logic [CNT_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == half_i - CNT_W'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i)
         cnt_q <= '0;
      else if (tick_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/spi_ctl_csdec.sv
module spi_ctl_csdec #(
   parameter int NUM_CS = 4,
   parameter int SEL_W  = 2
) (
   input  logic              active_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [NUM_CS-1:0] cs_n_o
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      assign cs_n_o[i] = !(active_i && (sel_i == SEL_W'(i)));
   end
endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
   import spi_ctl_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int NUM_CS   = 4,
   parameter int CTRL_OFS = 0,
   parameter int DATA_OFS = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic [NUM_CS-1:0] cs_n_o
);
   localparam int TIME_W = 8;
   localparam int SEL_W  = 2;
   localparam int BITS_W = $clog2(DATA_W + 1);

   if (DATA_W != 32) begin : g_bad_width
      $error("spi_ctl_master: control layout needs DATA_W of 32");
   end
   if (NUM_CS < 1 || NUM_CS > (1 << SEL_W)) begin : g_bad_cs
      $error("spi_ctl_master: NUM_CS must be 1 to 4");
   end
   if (CTRL_OFS == DATA_OFS || CTRL_OFS >= (1 << ADDR_W) || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("spi_ctl_master: register offsets overlap or do not fit");
   end

   spi_state_t         st_q;
   spi_cfg_t           cfg_q;
   logic [DATA_W-1:0]  dat_q;
   logic               sck_q, smp_q;
   logic [BITS_W-1:0]  bit_q;
   logic [TIME_W-1:0]  gcnt_q;

   logic               busy_w, tick_w, ctrl_hit, data_hit;
   logic [TIME_W-1:0]  half_w, guard_w;
   logic [BITS_W-1:0]  nbits_w;

   assign busy_w   = (st_q != ST_IDLE);
   assign ctrl_hit = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_OFS));
   assign data_hit = reg_we_i && (reg_addr_i == ADDR_W'(DATA_OFS));
   assign half_w   = (cfg_q.period[7:1] == '0) ? TIME_W'(1) : {1'b0, cfg_q.period[7:1]};
   assign guard_w  = (cfg_q.guard == '0) ? TIME_W'(1) : cfg_q.guard;
   assign nbits_w  = BITS_W'({1'b0, cfg_q.len_code} + 3'd1) << 3;

   spi_ctl_tick #(.CNT_W(TIME_W)) u_tick (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  (st_q == ST_SHIFT),
      .half_i (half_w),
      .tick_o (tick_w)
   );

   spi_ctl_csdec #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_csdec (
      .active_i (busy_w),
      .sel_i    (cfg_q.cs_sel),
      .cs_n_o   (cs_n_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q   <= ST_IDLE;
         cfg_q  <= '0;
         dat_q  <= '0;
         sck_q  <= 1'b0;
         smp_q  <= 1'b0;
         bit_q  <= '0;
         gcnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (data_hit)
                  dat_q <= reg_wdata_i;
               if (ctrl_hit) begin
                  cfg_q <= reg_wdata_i[CFG_W-1:0];
                  if (reg_wdata_i[START_BIT]) begin
                     st_q   <= ST_SETUP;
                     gcnt_q <= '0;
                     bit_q  <= '0;
                  end
               end
            end
            ST_SETUP: begin
               if (gcnt_q == guard_w - TIME_W'(1)) begin
                  st_q  <= ST_SHIFT;
                  sck_q <= 1'b1;
                  smp_q <= miso_i;
               end else begin
                  gcnt_q <= gcnt_q + TIME_W'(1);
               end
            end
            ST_SHIFT: begin
               if (tick_w) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     smp_q <= miso_i;
                  end else begin
                     sck_q <= 1'b0;
                     dat_q <= {dat_q[DATA_W-2:0], smp_q};
                     bit_q <= bit_q + BITS_W'(1);
                     if (bit_q == nbits_w - BITS_W'(1)) begin
                        st_q   <= ST_HOLD;
                        gcnt_q <= '0;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (gcnt_q == guard_w - TIME_W'(1))
                  st_q <= ST_IDLE;
               else
                  gcnt_q <= gcnt_q + TIME_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sck_o  = sck_q;
   assign mosi_o = ((st_q == ST_SETUP) || (st_q == ST_SHIFT)) && (cfg_q.op != OP_READ)
                   ? dat_q[DATA_W-1] : 1'b0;

   always_comb begin
      if (reg_addr_i == ADDR_W'(CTRL_OFS))
         reg_rdata_o = {busy_w, 1'b0, cfg_q};
      else if (reg_addr_i == ADDR_W'(DATA_OFS))
         reg_rdata_o = dat_q;
      else
         reg_rdata_o = '0;
   end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              sck,
   input logic              mosi,
   input logic [NUM_CS-1:0] cs_n
);
   // R9
   cs_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));

   // R6
   sck_idle_chk: assert property (@(posedge clk) disable iff (rst) (&cs_n) |-> !sck);

   // R6
   mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) (sck && $past(sck)) |-> $stable(mosi));

   // R7
   cs_on_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $onehot(~cs_n));

   // R8
   cs_off_done_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (&cs_n));

   // R8
   sck_low_done_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> !sck);
endmodule

bind spi_ctl_master spi_ctl_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk  (clk_i),
   .rst  (rst_i),
   .busy (busy_w),
   .sck  (sck_o),
   .mosi (mosi_o),
   .cs_n (cs_n_o)
);

// File: tb/test_spi_ctl_master.sv
module test_spi_ctl_master;
   logic        clk = 1'b0, rst = 1'b1, we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        sck, mosi, miso;
   logic [3:0]  cs_n;

   always #10 clk = ~clk;

   spi_ctl_master i_spi_ctl_master (
      .clk_i (clk), .rst_i (rst), .reg_we_i (we), .reg_addr_i (addr),
      .reg_wdata_i (wdata), .reg_rdata_o (rdata), .sck_o (sck),
      .mosi_o (mosi), .miso_i (miso), .cs_n_o (cs_n)
   );

   int checks = 0, fails = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // slave model: MISO from s_tx MSB first, updated on falling SCK
   logic [31:0] s_tx = '0, s_rx = '0;
   int          s_bit = 0;
   logic        cs_all;
   assign cs_all = &cs_n;
   assign miso = (s_bit < 32) ? s_tx[5'(31 - s_bit)] : 1'b0;
   always @(negedge sck or posedge cs_all) begin
      if (cs_all) s_bit <= 0;
      else        s_bit <= s_bit + 1;
   end
   always @(posedge sck or negedge cs_all) begin
      if (sck) s_rx <= {s_rx[30:0], mosi};
      else     s_rx <= '0;
   end

   typedef struct {
      int          sel;
      int          guard;
      int          half;
      int          nb;
      logic [31:0] bits;
   } item_t;
   item_t exp_q[$];

   // monitor: measures pin timing and compares with the scoreboard
   bit in_x = 0;
   int runlen, setup_len, rises, hmin, hmax, sel_seen;
   logic prev_sck;
   always @(negedge clk) begin
      if (rst) begin
         in_x = 0;
      end else if (!in_x && !cs_all) begin
         in_x = 1; runlen = 1; rises = 0; setup_len = -1;
         hmin = 1 << 20; hmax = 0; prev_sck = sck; sel_seen = -1;
         for (int i = 0; i < 4; i++) if (!cs_n[i]) sel_seen = i;
         if ($countones(~cs_n) != 1) chk("R9 one cs low", 32'($countones(~cs_n)), 1);
      end else if (in_x) begin
         if (cs_all) begin
            in_x = 0;
            if (exp_q.size() == 0) begin
               chk("R2 unexpected transfer", 1, 0);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               chk("R9 cs index", 32'(sel_seen), 32'(e.sel));
               chk("R7 setup clocks", 32'(setup_len), 32'(e.guard));
               chk("R8 hold clocks", 32'(runlen), 32'(e.guard));
               chk("R6 half min", 32'(hmin), 32'(e.half));
               chk("R6 half max", 32'(hmax), 32'(e.half));
               chk("R3 rising edges", 32'(rises), 32'(e.nb));
               chk("R4 R5 mosi bits", (e.nb == 32) ? s_rx : (s_rx & ((32'd1 << e.nb) - 1)), e.bits);
            end
         end else if (sck !== prev_sck) begin
            if (sck && rises == 0) setup_len = runlen;
            else begin
               if (runlen < hmin) hmin = runlen;
               if (runlen > hmax) hmax = runlen;
            end
            if (sck) rises++;
            runlen = 1;
            prev_sck = sck;
         end else begin
            runlen++;
         end
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int n = 0; n < 20000; n++) begin
         @(negedge clk);
         rd(4'h0, d);
         if (!d[31]) return;
      end
      chk("R2 busy never cleared", 1, 0);
   endtask

   function automatic logic [31:0] cword(bit go, int sel, int op, int cnt, int per, int grd, int aux);
      return {go, 1'b0, 2'(sel), 2'(op), 2'(cnt), 8'(per), 8'(grd), 8'(aux)};
   endfunction

   // driver: programs one transfer and pushes what the pins must show
   task automatic xfer(int sel, int op, int cnt, int per, int grd, logic [31:0] data, logic [31:0] slv);
      item_t       e;
      logic [31:0] w, d;
      e.sel   = sel;
      e.nb    = (cnt + 1) * 8;
      e.half  = ((per >> 1) == 0) ? 1 : (per >> 1);
      e.guard = (grd == 0) ? 1 : grd;
      e.bits  = (op == 1) ? 32'd0 : (data >> (32 - e.nb));
      exp_q.push_back(e);
      s_tx = slv;
      wr(4'h4, data);
      w = cword(1'b1, sel, op, cnt, per, grd, 8'h5A);
      wr(4'h0, w);
      rd(4'h0, d);
      chk("R2 busy set", 32'(d[31]), 1);
      chk("R1 ctrl fields", d, w);
      wait_idle();
      rd(4'h4, d);
      chk("R5 data after", d, (data << e.nb) | (slv >> (32 - e.nb)));
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, w;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      rd(4'h0, d); chk("R11 ctrl reset", d, 0);
      rd(4'h4, d); chk("R11 data reset", d, 0);
      chk("R11 cs high", 32'(cs_n), 32'hF);
      chk("R11 sck low", 32'(sck), 0);
      rd(4'h8, d); chk("R1 unmapped reads 0", d, 0);

      // status command then one-byte read
      xfer(0, 0, 0, 8'h10, 2, 32'h0500_0000, 32'h0);
      xfer(0, 1, 0, 8'h10, 2, 32'h0000_0000, 32'hA500_0000);
      // erase opcode plus address, other selects and timings
      xfer(2, 0, 3, 6, 3, 32'hD812_3456, 32'h0F0F_0F0F);
      xfer(3, 1, 3, 4, 1, 32'h1111_2222, 32'hCAFE_F00D);
      xfer(1, 2, 1, 1, 0, 32'hBEEF_0000, 32'h8001_0000);
      xfer(1, 0, 2, 0, 5, 32'h9C3A_7100, 32'h0);

      // R2 and R1: no start, reserved bit set
      w = cword(1'b0, 2, 1, 2, 9, 4, 8'h33);
      wr(4'h0, w | 32'h4000_0000);
      rd(4'h0, d); chk("R1 R2 stored, bit30 zero", d, w);
      repeat (10) @(negedge clk);
      chk("R2 no start keeps cs high", 32'(cs_n), 32'hF);

      // R10: writes during a transfer are ignored
      begin
         item_t e;
         e.sel = 1; e.nb = 32; e.half = 8; e.guard = 2; e.bits = 32'h1234_5678;
         exp_q.push_back(e);
         s_tx = 32'h0;
         wr(4'h4, 32'h1234_5678);
         w = cword(1'b1, 1, 0, 3, 8'h10, 2, 8'h01);
         wr(4'h0, w);
         repeat (20) @(negedge clk);
         wr(4'h0, cword(1'b1, 3, 1, 0, 2, 7, 8'hFF));
         wr(4'h4, 32'hFFFF_FFFF);
         rd(4'h0, d); chk("R10 ctrl write ignored", d, w);
         wait_idle();
         rd(4'h4, d); chk("R10 data write ignored", d, 32'h0);
      end

      // R11: reset in the middle of a transfer
      wr(4'h4, 32'hAAAA_5555);
      wr(4'h0, cword(1'b1, 0, 0, 3, 8'h10, 2, 0));
      repeat (30) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd(4'h0, d); chk("R11 busy cleared", d, 0);
      rd(4'h4, d); chk("R11 data cleared", d, 0);
      chk("R11 cs released", 32'(cs_n), 32'hF);
      chk("R11 sck low", 32'(sck), 0);
      chk("R11 mosi low", 32'(mosi), 0);
      repeat (5) @(negedge clk);
      chk("R3 all transfers seen", 32'(exp_q.size()), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule